// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block moves an 18-bit word between two buses, side A and side B, in either direction. Each direction has its own storage stage, its own output enable, its own latch enable and its own capture strobe. The storage stage of a direction is one element per bit that can do three things:

- pass the input straight through while latch enable is high;
- hold its value while latch enable is low and the strobe is steady;
- load the input when the strobe falls while latch enable is low.

The pads are not inside the block. Each side is presented as an input vector, an output-data vector and an output-enable bit, which a pad ring or bus fabric turns into a three-state pin. The output data reads zero whenever its enable is off.

The A-to-B enable is active high and the B-to-A enable is active low. A contention flag shows when both sides would be driven at once.

The block runs on one system clock, `clk`. The two capture strobes are treated as data levels and sampled on that clock. A strobe fall is the case where the strobe was high at one `clk` edge and is low at the next. Transparency is combinational from the input vector to the output vector. Storage power-up contents are not defined. A clear input zeroes the storage and acts only while latch enable is low.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: The data path is WIDTH (default 18) bits in each direction. `b_out` comes only from `a_in` under the controls `le_ab`, `ck_ab` and `oe_ab`. `a_out` comes only from `b_in` under the controls `le_ba`, `ck_ba` and `oe_ba_n`. Neither direction's controls affect the other direction.
- R2: While a direction's latch enable is 1, its output equals its current input in the same cycle, with no `clk` edge needed. Its storage takes the input at every `clk` edge.
- R3: While latch enable is 0 and no strobe fall is sampled, the stored word is unchanged and the output shows it, whatever the input does.
- R4: With latch enable at 0, a direction captures its input at a `clk` edge where its strobe is 0 and was 1 at the previous edge. The captured value is on the output from that edge on.
- R5: `b_oe` equals `oe_ab` (active high). While `oe_ab` is 0, `b_out` is all zeros. The storage still updates while the output is disabled.
- R6: `a_oe` is the inverse of `oe_ba_n` (active low). While `oe_ba_n` is 1, `a_out` is all zeros.
- R7: If latch enable falls while the strobe is already 0, the output keeps the word that was present in the last cycle with latch enable at 1. It keeps that word until the next strobe fall.
- R8: `clr` at 1 with latch enable at 0 zeroes that direction's storage at the next `clk` edge, and clear wins over a capture at the same edge. With latch enable at 1, `clr` has no effect.
- R9: `contention` is 1 in exactly the cycles where `oe_ab` is 1 and `oe_ba_n` is 0.
- R10: While `rst_n` is 0, no strobe fall is detected, and the strobe is taken as 0 at the first edge after release. `rst_n` does not change the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the strobe edge detectors |
| clr | input | 1 | Clears the storage of any direction whose latch enable is low |
| a_in | input | WIDTH | Data arriving from bus A |
| b_in | input | WIDTH | Data arriving from bus B |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| ck_ab | input | 1 | A-to-B capture strobe, captures on fall |
| ck_ba | input | 1 | B-to-A capture strobe, captures on fall |
| oe_ab | input | 1 | A-to-B output enable, active high |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_out | output | WIDTH | Data driven toward bus A, zero when disabled |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | WIDTH | Data driven toward bus B, zero when disabled |
| b_oe | output | 1 | Drive enable for bus B |
| contention | output | 1 | Both buses enabled in the same cycle |

## Verification
The enables, the contention flag and the transparent path act in the same cycle: their values are due as soon as the inputs settle. A capture, a clear or a transparent load changes the stored word at the rising `clk` edge that follows the stimulus. A strobe fall therefore needs the strobe high at one edge and low at the next, and the new word shows from that second edge. The bench drives all inputs on the falling `clk` edge and checks one time unit later. It advances its reference model at each rising edge from the same stable input values, so every compare sees state that is exactly one edge old.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Operation applied to a storage stage at one clk edge, in priority order
   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_PASS = 2'd1,
      ST_CLR  = 2'd2,
      ST_CAPT = 2'd3
   } store_op_e;

   // Decode the per-edge operation: pass > clear > capture > hold
   function automatic store_op_e pick_op(input logic le, input logic clr, input logic fall);
      if (le)        return ST_PASS;
      else if (clr)  return ST_CLR;
      else if (fall) return ST_CAPT;
      else           return ST_HOLD;
   endfunction

endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic fall
);

   logic prev_q;

   // previous strobe level, forced low in reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= strobe;
   end

   assign fall = prev_q & ~strobe;

   // R10: no edge is reported while reset is held
   assert_no_fall_in_rst_R10: assert property (@(posedge clk) !rst_n |-> !fall);

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH   = 18,
   parameter bit          HAS_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             le,
   input  logic             fall,
   input  logic             clr,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] flow
);

   initial begin
      assert (WIDTH > 0) else $fatal(1, "xcvr_store: WIDTH must be positive");
   end

   logic             clr_eff;
   logic [WIDTH-1:0] q_r;
   store_op_e        op;

   generate
      if (HAS_CLR) begin : g_clr
         assign clr_eff = clr;
      end else begin : g_noclr
         logic unused_clr;
         assign unused_clr = clr;
         assign clr_eff    = 1'b0;
      end
   endgenerate

   assign op = pick_op(le, clr_eff, fall);

   // storage has no reset: contents start undefined by design
   always_ff @(posedge clk) begin
      unique case (op)
         ST_PASS: q_r <= din;
         ST_CLR:  q_r <= '0;
         ST_CAPT: q_r <= din;
         default: q_r <= q_r;
      endcase
   end

   // transparent bypass while le is high
   assign flow = le ? din : q_r;

   assert_pass_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      le |=> (q_r == $past(din)));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!le && !fall && !clr_eff) |=> $stable(q_r));
   assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!le && fall && !clr_eff) |=> (q_r == $past(din)));
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!le && clr_eff) |=> (q_r == '0));

endmodule

// File: rtl/xcvr_port_drv.sv
module xcvr_port_drv #(
   parameter int unsigned WIDTH      = 18,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic             en_pin,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             oe
);

   initial begin
      assert (WIDTH > 0) else $fatal(1, "xcvr_port_drv: WIDTH must be positive");
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign oe = ~en_pin;
      end else begin : g_high
         assign oe = en_pin;
      end
   endgenerate

   assign dout = oe ? din : '0;

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
   parameter int unsigned WIDTH         = 18,
   parameter bit          OE_ACTIVE_LOW = 1'b0,
   parameter bit          HAS_CLR       = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             le,
   input  logic             strobe,
   input  logic             en_pin,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             oe
);

   logic             fall;
   logic [WIDTH-1:0] flow;

   xcvr_fall_det i_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe),
      .fall   (fall)
   );

   xcvr_store #(.WIDTH(WIDTH), .HAS_CLR(HAS_CLR)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (le),
      .fall  (fall),
      .clr   (clr),
      .din   (din),
      .flow  (flow)
   );

   xcvr_port_drv #(.WIDTH(WIDTH), .ACTIVE_LOW(OE_ACTIVE_LOW)) i_drv (
      .en_pin (en_pin),
      .din    (flow),
      .dout   (dout),
      .oe     (oe)
   );

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
   parameter int unsigned WIDTH   = 18,
   parameter bit          HAS_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             le_ab,
   input  logic             le_ba,
   input  logic             ck_ab,
   input  logic             ck_ba,
   input  logic             oe_ab,
   input  logic             oe_ba_n,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe,
   output logic             contention
);

   initial begin
      assert (WIDTH > 0) else $fatal(1, "bidir_reg_xcvr: WIDTH must be positive");
   end

   // A to B: active-high enable
   xcvr_dir #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0), .HAS_CLR(HAS_CLR)) i_ab (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .le     (le_ab),
      .strobe (ck_ab),
      .en_pin (oe_ab),
      .din    (a_in),
      .dout   (b_out),
      .oe     (b_oe)
   );

   // B to A: active-low enable
   xcvr_dir #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1), .HAS_CLR(HAS_CLR)) i_ba (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .le     (le_ba),
      .strobe (ck_ba),
      .en_pin (oe_ba_n),
      .din    (b_in),
      .dout   (a_out),
      .oe     (a_oe)
   );

   assign contention = a_oe & b_oe;

   assert_b_off_R5: assert property (@(posedge clk)
      !oe_ab |-> (!b_oe && (b_out == '0)));
   assert_a_off_R6: assert property (@(posedge clk)
      oe_ba_n |-> (!a_oe && (a_out == '0)));
   assert_contend_R9: assert property (@(posedge clk)
      contention == (oe_ab && !oe_ba_n));
   assert_pass_b_R2: assert property (@(posedge clk)
      (le_ab && oe_ab) |-> (b_out == a_in));

endmodule

// File: tb/test_bidir_reg_xcvr.sv
module test_bidir_reg_xcvr;

   localparam int          CLK_PERIOD = 10;
   localparam int unsigned W          = 18;
   localparam int          N_RAND     = 4000;

   logic         clk = 1'b0;
   logic         rst_n, clr;
   logic [W-1:0] a_in, b_in;
   logic         le_ab, le_ba, ck_ab, ck_ba, oe_ab, oe_ba_n;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe, contention;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // reference model state
   logic [W-1:0] m_qab, m_qba;
   logic         m_pab, m_pba;

   always #(CLK_PERIOD/2) clk = ~clk;

   bidir_reg_xcvr #(.WIDTH(W), .HAS_CLR(1'b1)) i_bidir_reg_xcvr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .a_in(a_in), .b_in(b_in),
      .le_ab(le_ab), .le_ba(le_ba), .ck_ab(ck_ab), .ck_ba(ck_ba),
      .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .a_out(a_out), .a_oe(a_oe),
      .b_out(b_out), .b_oe(b_oe), .contention(contention)
   );

   function automatic logic [W-1:0] exp_b();
      return oe_ab ? (le_ab ? a_in : m_qab) : '0;
   endfunction

   function automatic logic [W-1:0] exp_a();
      return !oe_ba_n ? (le_ba ? b_in : m_qba) : '0;
   endfunction

   task automatic model_edge();
      logic fab, fba;
      fab = m_pab & ~ck_ab;
      fba = m_pba & ~ck_ba;
      if (!rst_n) begin fab = 1'b0; fba = 1'b0; m_pab = 1'b0; m_pba = 1'b0; end
      else begin m_pab = ck_ab; m_pba = ck_ba; end
      if (le_ab) m_qab = a_in; else if (clr) m_qab = '0; else if (fab) m_qab = a_in;
      if (le_ba) m_qba = b_in; else if (clr) m_qba = '0; else if (fba) m_qba = b_in;
   endtask

   // one clk edge, then return at the falling edge ready for new inputs
   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic check_all(string tag_ab, string tag_ba);
      #1;
      chk(tag_ab, "b_out", b_out, exp_b());
      chk("R5", "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, oe_ab});
      chk(tag_ba, "a_out", a_out, exp_a());
      chk("R6", "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ~oe_ba_n});
      chk("R9", "contention", {{(W-1){1'b0}}, contention}, {{(W-1){1'b0}}, oe_ab & ~oe_ba_n});
   endtask

   function automatic string mode_tag(logic oe, logic le);
      if (!oe) return "R5/R6";
      if (le)  return "R2";
      return "R3/R4";
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_qab = '0; m_qba = '0; m_pab = 1'b0; m_pba = 1'b0;
      rst_n = 1'b0; clr = 1'b1; a_in = '0; b_in = '0;
      le_ab = 1'b0; le_ba = 1'b0; ck_ab = 1'b0; ck_ba = 1'b0;
      oe_ab = 1'b1; oe_ba_n = 1'b0;
      // R10: strobes toggle during reset; no capture may happen, clear zeroes storage
      tick();
      a_in = 18'h2AAAA; b_in = 18'h15555; ck_ab = 1'b1; ck_ba = 1'b1; clr = 1'b0;
      tick();
      ck_ab = 1'b0; ck_ba = 1'b0;
      tick();
      check_all("R10", "R10");
      chk("R8", "b_out after clear", b_out, '0);
      rst_n = 1'b1;
      tick();
      check_all("R10", "R10");

      // R2: transparent in both directions, same cycle
      le_ab = 1'b1; le_ba = 1'b1; a_in = 18'h12345; b_in = 18'h0BEEF;
      check_all("R2", "R2");
      a_in = 18'h3FFFF;
      check_all("R2", "R2");
      tick();

      // R7: drop le while strobe is low; last transparent word held
      le_ab = 1'b0; a_in = 18'h00777;
      check_all("R7", "R2");
      chk("R7", "b_out held", b_out, 18'h3FFFF);
      tick();
      a_in = 18'h01111;
      check_all("R7", "R2");
      // R4: strobe high then low captures
      ck_ab = 1'b1;
      tick();
      chk("R3", "b_out before fall", b_out, 18'h3FFFF);
      ck_ab = 1'b0; a_in = 18'h2C0DE;
      tick();
      a_in = 18'h00000;
      check_all("R4", "R2");
      chk("R4", "b_out captured", b_out, 18'h2C0DE);
      // R3: input changes, strobe steady high then steady low
      ck_ab = 1'b1; a_in = 18'h11111;
      tick();
      a_in = 18'h22222;
      check_all("R3", "R2");
      chk("R3", "b_out held", b_out, 18'h2C0DE);

      // R8: clear beats capture at the same edge
      ck_ab = 1'b0; clr = 1'b1; a_in = 18'h3ABCD;
      tick();
      clr = 1'b0;
      check_all("R8", "R8");
      chk("R8", "b_out cleared", b_out, '0);

      // R5: storage updates while disabled
      oe_ab = 1'b0; ck_ab = 1'b1;
      tick();
      ck_ab = 1'b0; a_in = 18'h1F0F0;
      tick();
      check_all("R5", "R2");
      oe_ab = 1'b1;
      check_all("R5", "R2");
      chk("R5", "b_out after re-enable", b_out, 18'h1F0F0);

      // R6 and R1: B-to-A disabled, independent of A-to-B controls
      oe_ba_n = 1'b1; le_ba = 1'b0;
      check_all("R6", "R6");
      chk("R6", "a_out disabled", a_out, '0);

      // random mixed stimulus, both directions
      for (int i = 0; i < N_RAND; i++) begin
         tick();
         a_in    = W'($urandom);
         b_in    = W'($urandom);
         le_ab   = ($urandom_range(0, 3) == 0);
         le_ba   = ($urandom_range(0, 3) == 0);
         ck_ab   = $urandom_range(0, 1) != 0;
         ck_ba   = $urandom_range(0, 1) != 0;
         oe_ab   = ($urandom_range(0, 4) != 0);
         oe_ba_n = ($urandom_range(0, 4) == 0) ? 1'b1 : ($urandom_range(0, 1) != 0);
         clr     = ($urandom_range(0, 31) == 0);
         check_all(mode_tag(oe_ab, le_ab), mode_tag(~oe_ba_n, le_ba));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule